// File: doc/BRIEF.md
# Pipelined Divide-by-Three with Remainder

This block divides an unsigned word by three on every clock cycle and returns both the quotient and the remainder, without a divider. It multiplies the input by a fixed-point reciprocal of three (all-ones word divided by three; 0x5555 for a 16-bit word) and keeps the upper half of the product as a trial quotient. It then forms three times that trial quotient as one addition (the quotient plus the quotient shifted left by one bit), subtracts the result from the input, and makes a single correction. The correction is needed because the reciprocal is slightly below one third, so the trial quotient can come out one too small.

The pipeline has four register stages: multiply, scale, subtract and correct. Each stage uses only values from the stage before it. A new operand is taken on every cycle and a valid flag travels alongside the data. A parameter chooses how the constant multiply is built: a plain product operator, or a sum of shifted copies of the input, one for each set bit of the constant. The register stages hold their contents through cycles that carry no data, so the outputs keep the last result until the next valid operand arrives.

Top module: `mod3_recip_pipe`

## Requirements
- R1: While `res_valid` is high, `res_rem` is 0, 1 or 2, given as a plain 2-bit binary number.
- R2: `res_valid` is high exactly four clock edges after the edge that sampled `op_valid` high, and low four edges after an edge that sampled it low. Back-to-back operands give back-to-back results with no bubbles.
- R3: For every input value `op_x`, the result carries `res_quo` = floor(`op_x`/3) and `res_rem` = `op_x` - 3*`res_quo`.
- R4: Inputs where the reciprocal product undershoots, such as 3, 6 and the all-ones word, still give the exact quotient and remainder. The trial quotient is never more than one below the true quotient.
- R5: While `res_valid` is high, `res_quo` never exceeds floor((2^DATA_W - 1)/3), which is 21845 for a 16-bit word.
- R6: A cycle with `op_valid` low has no effect. While `res_valid` is low, `res_rem` and `res_quo` keep the last valid result, whatever `op_x` carried during the idle cycles.
- R7: While `rst_n` is low and right after it, `res_valid`, `res_rem` and `res_quo` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Marks `op_x` as an operand this cycle |
| op_x | input | DATA_W | Unsigned dividend |
| res_valid | output | 1 | Marks the result outputs as fresh |
| res_rem | output | 2 | Remainder of `op_x` divided by three |
| res_quo | output | DATA_W | Quotient of `op_x` divided by three |

## Verification
The latency and exact-result properties assume that `op_valid` and `op_x` are driven to known values on every cycle after reset, and that reset stays low long enough to clear all four stage flags. They compare against input values from four edges earlier, and a cycle counter keeps them quiet until four edges have passed since reset. The bench drives every input well away from the rising edge, holds `op_valid` low during reset, and moves `op_x` freely during idle cycles, so the hold property is tested against operands that change. The stimulus covers the whole 16-bit input range back to back, then random operands mixed with random bubbles, so every undershoot case reaches the correction stage.

// File: rtl/mod3_pkg.sv
package mod3_pkg;

   localparam int REM_W    = 2;
   localparam int TRIAL_W  = 3;
   localparam int PIPE_LAT = 4;

   typedef logic [REM_W-1:0]   rem_t;
   typedef logic [TRIAL_W-1:0] trial_t;

   // fixed-point one-third: floor((2^w - 1) / 3), always just below 2^w/3
   function automatic logic [63:0] recip_third(input int w);
      logic [63:0] all_ones;
      all_ones = (64'd1 << w) - 64'd1;
      return all_ones / 64'd3;
   endfunction

   // largest quotient a w-bit dividend can give
   function automatic logic [63:0] max_quo(input int w);
      return ((64'd1 << w) - 64'd1) / 64'd3;
   endfunction

endpackage

// File: rtl/m3_mul_stage.sv
module m3_mul_stage #(
   parameter int DATA_W        = 16,
   parameter bit SHIFT_ADD_MUL = 1'b0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  i_vld,
   input  logic [DATA_W-1:0]     i_x,
   output logic                  o_vld,
   output logic [DATA_W-1:0]     o_x,
   output logic [2*DATA_W-1:0]   o_prod
);

   localparam int PROD_W = 2 * DATA_W;
   localparam logic [DATA_W-1:0] RECIP = DATA_W'(mod3_pkg::recip_third(DATA_W));

   logic [PROD_W-1:0] prod_d;

   generate
      if (SHIFT_ADD_MUL) begin : g_shift_add
         // one shifted copy of the operand for every set bit of the constant
         always_comb begin
            prod_d = '0;
            for (int b = 0; b < DATA_W; b++) begin
               if (RECIP[b]) prod_d = prod_d + (PROD_W'(i_x) << b);
            end
         end
      end else begin : g_operator
         assign prod_d = PROD_W'(i_x) * PROD_W'(RECIP);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         o_vld  <= 1'b0;
         o_x    <= '0;
         o_prod <= '0;
      end else begin
         o_vld <= i_vld;
         if (i_vld) begin
            o_x    <= i_x;
            o_prod <= prod_d;
         end
      end
   end

endmodule

// File: rtl/m3_scale_sub.sv
module m3_scale_sub #(
   parameter int DATA_W = 16
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   i_vld,
   input  logic [DATA_W-1:0]      i_x,
   input  logic [2*DATA_W-1:0]    i_prod,
   output logic                   o_vld,
   output logic [DATA_W-1:0]      o_q,
   output mod3_pkg::trial_t       o_trial
);

   localparam int TQ_W = DATA_W + 2;

   // scale stage: keep the upper half of the product as the trial quotient
   logic [DATA_W-1:0] q_scaled;
   logic [DATA_W-1:0] prod_low_unused;
   assign {q_scaled, prod_low_unused} = i_prod;

   logic              s2_vld;
   logic [DATA_W-1:0] s2_x;
   logic [DATA_W-1:0] s2_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s2_vld <= 1'b0;
         s2_x   <= '0;
         s2_q   <= '0;
      end else begin
         s2_vld <= i_vld;
         if (i_vld) begin
            s2_x <= i_x;
            s2_q <= q_scaled;
         end
      end
   end

   // subtract stage: 3q built as q + 2q, trial remainder fits in three bits
   logic [TQ_W-1:0]                       three_q;
   logic [TQ_W-1:0]                       diff;
   logic [TQ_W-mod3_pkg::TRIAL_W-1:0]     diff_high_unused;
   mod3_pkg::trial_t                      trial_d;

   assign three_q = {1'b0, s2_q, 1'b0} + {2'b00, s2_q};
   assign diff    = {2'b00, s2_x} - three_q;
   assign {diff_high_unused, trial_d} = diff;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         o_vld   <= 1'b0;
         o_q     <= '0;
         o_trial <= '0;
      end else begin
         o_vld <= s2_vld;
         if (s2_vld) begin
            o_q     <= s2_q;
            o_trial <= trial_d;
         end
      end
   end

   // trial quotient is the true one or one below it
   p_trial_q_close_r4: assert property (@(posedge clk) disable iff (!rst_n)
      s2_vld |-> ((s2_q == s2_x / DATA_W'(3)) || (s2_q + DATA_W'(1) == s2_x / DATA_W'(3))))
      else $error("trial quotient off by more than one");

   // so the trial remainder stays below twice the divisor
   p_trial_rem_r4: assert property (@(posedge clk) disable iff (!rst_n)
      o_vld |-> (o_trial < 3'd6))
      else $error("trial remainder out of range");

endmodule

// File: rtl/m3_fixup.sv
module m3_fixup #(
   parameter int DATA_W = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 i_vld,
   input  logic [DATA_W-1:0]    i_q,
   input  mod3_pkg::trial_t     i_trial,
   output logic                 o_vld,
   output logic [DATA_W-1:0]    o_quo,
   output mod3_pkg::rem_t       o_rem
);

   logic             over;
   mod3_pkg::rem_t   rem_d;
   logic [DATA_W-1:0] quo_d;

   assign over  = (i_trial >= 3'd3);
   assign rem_d = over ? mod3_pkg::rem_t'(i_trial - 3'd3) : i_trial[1:0];
   assign quo_d = over ? i_q + DATA_W'(1) : i_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         o_vld <= 1'b0;
         o_quo <= '0;
         o_rem <= '0;
      end else begin
         o_vld <= i_vld;
         if (i_vld) begin
            o_quo <= quo_d;
            o_rem <= rem_d;
         end
      end
   end

   p_rem_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
      o_vld |-> (o_rem <= 2'd2))
      else $error("remainder above two");

endmodule

// File: rtl/mod3_recip_pipe.sv
module mod3_recip_pipe #(
   parameter int DATA_W        = 16,
   parameter bit SHIFT_ADD_MUL = 1'b0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  op_valid,
   input  logic [DATA_W-1:0]     op_x,
   output logic                  res_valid,
   output logic [1:0]            res_rem,
   output logic [DATA_W-1:0]     res_quo
);

   localparam int PROD_W = 2 * DATA_W;
   localparam logic [DATA_W-1:0] QUO_MAX = DATA_W'(mod3_pkg::max_quo(DATA_W));

   initial begin
      assert (DATA_W >= 2 && DATA_W <= 32)
         else $error("DATA_W must lie in 2..32");
   end

   logic                  m_vld;
   logic [DATA_W-1:0]     m_x;
   logic [PROD_W-1:0]     m_prod;
   logic                  t_vld;
   logic [DATA_W-1:0]     t_q;
   mod3_pkg::trial_t      t_trial;
   mod3_pkg::rem_t        f_rem;

   m3_mul_stage #(.DATA_W(DATA_W), .SHIFT_ADD_MUL(SHIFT_ADD_MUL)) u_mul (
      .clk    (clk),
      .rst_n  (rst_n),
      .i_vld  (op_valid),
      .i_x    (op_x),
      .o_vld  (m_vld),
      .o_x    (m_x),
      .o_prod (m_prod)
   );

   m3_scale_sub #(.DATA_W(DATA_W)) u_sub (
      .clk     (clk),
      .rst_n   (rst_n),
      .i_vld   (m_vld),
      .i_x     (m_x),
      .i_prod  (m_prod),
      .o_vld   (t_vld),
      .o_q     (t_q),
      .o_trial (t_trial)
   );

   m3_fixup #(.DATA_W(DATA_W)) u_fix (
      .clk     (clk),
      .rst_n   (rst_n),
      .i_vld   (t_vld),
      .i_q     (t_q),
      .i_trial (t_trial),
      .o_vld   (res_valid),
      .o_quo   (res_quo),
      .o_rem   (f_rem)
   );

   assign res_rem = f_rem;

   // edges seen since reset, saturating at the pipeline depth
   logic [2:0] edges_seen;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   edges_seen <= '0;
      else if (edges_seen != 3'(mod3_pkg::PIPE_LAT)) edges_seen <= edges_seen + 3'd1;
   end

   p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (edges_seen == 3'(mod3_pkg::PIPE_LAT)) |-> (res_valid == $past(op_valid, 4)))
      else $error("valid flag not delayed by four edges");

   p_exact_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ((edges_seen == 3'(mod3_pkg::PIPE_LAT)) && res_valid) |->
         (({2'b00, res_quo} + {1'b0, res_quo, 1'b0} + {{DATA_W{1'b0}}, res_rem})
            == {2'b00, $past(op_x, 4)}))
      else $error("quotient and remainder do not rebuild the dividend");

   p_quo_max_r5: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> (res_quo <= QUO_MAX))
      else $error("quotient above its ceiling");

   p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ((edges_seen != 3'd0) && !res_valid) |-> ($stable(res_rem) && $stable(res_quo)))
      else $error("outputs moved without a valid result");

endmodule

// File: tb/sim_mod3_recip_pipe.sv
module sim_mod3_recip_pipe;

   localparam int  W          = 16;
   localparam time CLK_PERIOD = 10ns;
   localparam int  WATCHDOG   = 150000;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         op_valid = 1'b0;
   logic [W-1:0] op_x = '0;
   logic         res_valid;
   logic [1:0]   res_rem;
   logic [W-1:0] res_quo;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   // expected-side history: entry 0 is the newest
   bit         hv [0:3];
   int         hx [0:3];
   bit         hcorner [0:3];
   int         last_rem = 0;
   int         last_quo = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mod3_recip_pipe #(.DATA_W(W)) u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .op_valid  (op_valid),
      .op_x      (op_x),
      .res_valid (res_valid),
      .res_rem   (res_rem),
      .res_quo   (res_quo)
   );

   function automatic int exp_quo(input int x);
      return x / 3;
   endfunction

   function automatic int exp_rem(input int x);
      return x % 3;
   endfunction

   task automatic check(input string req, input int act, input int expv);
      total++;
      if (act != expv) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
      end
   endtask

   // compare outputs against the operand pushed four negedges ago, then drive
   task automatic step(input bit v, input int x, input bit corner);
      @(negedge clk);
      if (hv[3]) begin
         check("R2 valid", int'(res_valid), 1);
         check(hcorner[3] ? "R4 rem" : "R3 rem", int'(res_rem), exp_rem(hx[3]));
         check(hcorner[3] ? "R4 quo" : "R3 quo", int'(res_quo), exp_quo(hx[3]));
         check("R1 rem range", int'(res_rem <= 2'd2), 1);
         check("R5 quo ceiling", int'(res_quo <= 16'd21845), 1);
         last_rem = exp_rem(hx[3]);
         last_quo = exp_quo(hx[3]);
      end else begin
         check("R2 idle", int'(res_valid), 0);
         check("R6 hold rem", int'(res_rem), last_rem);
         check("R6 hold quo", int'(res_quo), last_quo);
      end
      for (int i = 3; i > 0; i--) begin
         hv[i] = hv[i-1];
         hx[i] = hx[i-1];
         hcorner[i] = hcorner[i-1];
      end
      hv[0] = v;
      hx[0] = x;
      hcorner[0] = corner;
      op_valid = v;
      op_x = W'(x);
   endtask

   initial begin
      for (int i = 0; i < 4; i++) begin
         hv[i] = 1'b0;
         hx[i] = 0;
         hcorner[i] = 1'b0;
      end
      void'($urandom(32'd2718));
      repeat (3) @(negedge clk);
      // R7: reset state while held
      check("R7 valid", int'(res_valid), 0);
      check("R7 rem", int'(res_rem), 0);
      check("R7 quo", int'(res_quo), 0);
      rst_n = 1'b1;
      // R7 again right after release, with an idle input carrying junk
      op_x = 16'hBEEF;
      @(negedge clk);
      check("R7 valid after", int'(res_valid), 0);
      check("R7 quo after", int'(res_quo), 0);

      // R4 undershoot corners back to back
      step(1'b1, 3, 1'b1);
      step(1'b1, 6, 1'b1);
      step(1'b1, 65535, 1'b1);
      step(1'b1, 65534, 1'b1);
      step(1'b1, 65533, 1'b1);
      step(1'b1, 0, 1'b1);
      step(1'b1, 49152, 1'b1);
      step(1'b1, 32769, 1'b1);
      // R6: idle cycles with a moving op_x must not disturb outputs
      for (int i = 0; i < 8; i++) step(1'b0, 1000 + i * 777, 1'b0);

      // R3: every 16-bit value, back to back
      for (int x = 0; x < 65536; x++) step(1'b1, x, 1'b0);

      // R2/R6: random operands with random bubbles
      for (int i = 0; i < 3000; i++) begin
         int r;
         r = int'($urandom_range(0, 65535));
         step(($urandom_range(0, 3) != 0), r, 1'b0);
      end

      // drain
      for (int i = 0; i < 6; i++) step(1'b0, int'($urandom_range(0, 65535)), 1'b0);

      if (!done) begin
         done = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule